// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast functional clock into the oversampling tick that a serial transmitter and receiver step on. A first stage divides the clock by a whole ratio from 1 to 8. A second stage counts the prescaled clock against a divisor. The divisor has a 16-bit whole part and a 6-bit fractional part in 1/64 steps. A 6-bit phase accumulator adds the fraction once per tick period. Whenever it overflows, that period runs one prescaled clock longer, so the average period matches the fractional divisor over every window of 64 periods.

A third stage counts ticks and raises a bit strobe on every 16th, 8th or 3rd tick, as the oversampling mode selects. Software computes the divisor as prescaled clock / (oversampling x baud), with the fraction rounded to the nearest 1/64. For example, a 40 MHz clock, ratio 1, 16x oversampling and 19200 baud give a whole part of 130 and a fraction of 13. A whole part of zero stops the generator. Setting changes made while it runs are held back until the current period ends.

Top module: `baud_frac_gen`

## Requirements
- R1: After reset, and on every cycle after one where `enable` is low, `os_tick` and `bit_tick` are low.
- R2: The 3-bit `prescale_sel` value S sets a prescale ratio of S+1, from 1 to 8, and every tick period lasts that ratio times its length in prescaled clocks.
- R3: Periods are numbered p = 1, 2, ... from enable. Period p lasts `div_int` + c(p) prescaled clocks, where c(p) = floor(p*F/64) - floor((p-1)*F/64) and F is `div_frac`.
- R4: Any 64 consecutive tick periods together last ratio x (64 x `div_int` + `div_frac`) clock cycles. For example, 130 and 13 at ratio 1 give 8333 cycles.
- R5: While the applied whole divisor is zero, no ticks are produced and the fraction has no effect. Writing a nonzero whole part while enabled starts ticking, with the new divisor.
- R6: `ovs_sel` picks N ticks per bit: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 3 and 2'b11 gives 16. Counting ticks from 1 after enable, `bit_tick` is high exactly on the ticks whose number is a multiple of N.
- R7: `bit_tick` is never high without `os_tick`.
- R8: Changes to the divisor, prescale or mode made while running take effect at the next period boundary. The period in progress finishes with its old length.
- R9: Dropping `enable` clears the accumulator, counters and tick phase. A later enable restarts the sequence of R3 and R6 from period 1.
- R10: A whole divisor of 1 with fraction 0 and ratio 1 yields `os_tick` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the generator; low clears all state |
| prescale_sel | input | 3 | Prescale ratio minus one |
| div_int | input | 16 | Whole part of the divisor |
| div_frac | input | 6 | Fractional part of the divisor, in 1/64 units |
| ovs_sel | input | 2 | Oversampling mode (16, 8, 3, 16) |
| os_tick | output | 1 | One-cycle oversampling tick |
| bit_tick | output | 1 | One-cycle bit strobe, coincident with a tick |

## Verification
The properties assume the settings are only ever changed at the generator's own period boundaries or while it is idle. They also assume that the bit-counter check sees no mode switch while a bit is mid-count. The stimulus keeps within this in three ways:
- It sets every configuration with `enable` low.
- It changes a live setting only once, in the reload test, and with 16x mode left unchanged.
- It makes the zero-divisor exit from the halted state, where no period is in progress.

Tick gaps are compared with the carry formula of R3 for every fraction from 0 to 63, every prescale ratio and every oversampling code.

// File: rtl/baud_gen_pkg.sv
// Package: shared mode encoding and helpers for the fractional baud generator.
// Assumes: the oversampling mode code is two bits; code 3 behaves as 16x.
package baud_gen_pkg;

    typedef enum logic [1:0] {
        OVS_X16     = 2'b00,
        OVS_X8      = 2'b01,
        OVS_X3      = 2'b10,
        OVS_X16_ALT = 2'b11
    } ovs_mode_e;

    localparam int OS_CNT_W = 5;

    // Number of ticks that make up one bit for a given mode code.
    function automatic logic [OS_CNT_W-1:0] ovs_ticks(input logic [1:0] mode);
        logic [OS_CNT_W-1:0] n;
        case (ovs_mode_e'(mode))
            OVS_X8:  n = OS_CNT_W'(8);
            OVS_X3:  n = OS_CNT_W'(3);
            default: n = OS_CNT_W'(16);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/bg_prescaler.sv
// Module: whole-ratio prescaler. Emits a one-cycle step every (ratio_m1+1)
// clocks while run is high.
// Assumes: ratio_m1 only changes on a cycle where step is high, or while run is low.
module bg_prescaler #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PRE_W-1:0] ratio_m1,
    output logic             step
);

    logic [PRE_W-1:0] pre_cnt;

    // Step fires when the phase counter reaches the programmed ratio.
    always_comb begin
        step = run && (pre_cnt == ratio_m1);
    end

    // Phase counter: cleared when idle, wraps on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
        end else if (step) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + PRE_W'(1);
        end
    end

endmodule

// File: rtl/bg_frac_divider.sv
// Module: fractional divider. Counts prescaled steps. Each period lasts
// dint steps, plus one step when the phase accumulator carries.
// Assumes: dint is nonzero whenever run is high; dint and dfrac change only
// at a period end or while run is low.
module bg_frac_divider #(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step,
    input  logic [INT_W-1:0]  dint,
    input  logic [FRAC_W-1:0] dfrac,
    output logic              period_end,
    output logic [INT_W-1:0]  cnt_q
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   acc_sum;
    logic              carry;
    logic [INT_W:0]    end_val;

    // Accumulator sum for the current period, and its carry bit.
    always_comb begin
        acc_sum = {1'b0, acc_q} + {1'b0, dfrac};
        carry   = acc_sum[FRAC_W];
    end

    // Last step index of this period: dint-1, or dint when lengthened.
    always_comb begin
        end_val = {1'b0, dint} - (INT_W+1)'(1) + {{INT_W{1'b0}}, carry};
    end

    // Period ends on the step that reaches the last index.
    always_comb begin
        period_end = run && step && ({1'b0, cnt_q} == end_val);
    end

    // Step counter and phase accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (period_end) begin
            cnt_q <= '0;
            acc_q <= acc_sum[FRAC_W-1:0];
        end else if (step) begin
            cnt_q <= cnt_q + INT_W'(1);
        end
    end

endmodule

// File: rtl/bg_os_counter.sv
// Module: oversampling counter. Counts ticks and flags the tick that closes a bit.
// Assumes: a mode change lands on a tick boundary. A count already past the new
// limit closes the bit on the next tick.
module bg_os_counter
    import baud_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       tick,
    input  logic [1:0] mode,
    output logic       bit_end
);

    logic [OS_CNT_W-1:0] os_cnt;
    logic [OS_CNT_W-1:0] last_idx;

    // Index of the final tick of a bit for the active mode.
    always_comb begin
        last_idx = ovs_ticks(mode) - OS_CNT_W'(1);
        bit_end  = tick && (os_cnt >= last_idx);
    end

    // Tick counter within a bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            os_cnt <= '0;
        end else if (bit_end) begin
            os_cnt <= '0;
        end else if (tick) begin
            os_cnt <= os_cnt + OS_CNT_W'(1);
        end
    end

endmodule

// File: rtl/baud_frac_gen.sv
// Module: top of the fractional baud tick generator. Holds the applied
// settings, which are taken from the inputs while idle or at a period end.
// Chains prescaler, fractional divider and oversampling counter, and
// registers the strobes.
// Assumes: the inputs are synchronous to clk.
module baud_frac_gen #(
    parameter int PRE_W  = 3,
    parameter int INT_W  = 16,
    parameter int FRAC_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PRE_W-1:0]  prescale_sel,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic [1:0]        ovs_sel,
    output logic              os_tick,
    output logic              bit_tick
);

    logic [PRE_W-1:0]  sh_pre;
    logic [INT_W-1:0]  sh_int;
    logic [FRAC_W-1:0] sh_frac;
    logic [1:0]        sh_ovs;
    logic              run;
    logic              pre_step;
    logic              period_end;
    logic              bit_end;
    logic [INT_W-1:0]  div_cnt;

    // Generator runs only when enabled with a nonzero applied whole divisor.
    always_comb begin
        run = enable && (sh_int != '0);
    end

    // Applied settings: follow the inputs while idle, refresh at each period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pre  <= '0;
            sh_int  <= '0;
            sh_frac <= '0;
            sh_ovs  <= '0;
        end else if (!run || period_end) begin
            sh_pre  <= prescale_sel;
            sh_int  <= div_int;
            sh_frac <= div_frac;
            sh_ovs  <= ovs_sel;
        end
    end

    bg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ratio_m1 (sh_pre),
        .step     (pre_step)
    );

    bg_frac_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .step       (pre_step),
        .dint       (sh_int),
        .dfrac      (sh_frac),
        .period_end (period_end),
        .cnt_q      (div_cnt)
    );

    bg_os_counter u_os (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (period_end),
        .mode    (sh_ovs),
        .bit_end (bit_end)
    );

    // Output strobes, registered for clean one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            os_tick  <= 1'b0;
            bit_tick <= 1'b0;
        end else begin
            os_tick  <= period_end;
            bit_tick <= bit_end;
        end
    end

endmodule

// File: rtl/baud_frac_gen_chk.sv
// Module: property checker for baud_frac_gen, attached with bind.
// Assumes: the oversampling mode is not switched while a bit is mid-count.
module baud_frac_gen_chk #(
    parameter int INT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             os_tick,
    input logic             bit_tick,
    input logic [INT_W-1:0] sh_int,
    input logic [INT_W-1:0] cnt
);

    logic [4:0] ticks_since_bit;

    // Count output ticks since the last bit strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || bit_tick) begin
            ticks_since_bit <= '0;
        end else if (os_tick && ticks_since_bit != 5'd31) begin
            ticks_since_bit <= ticks_since_bit + 5'd1;
        end
    end

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !os_tick && !bit_tick);

    assert_zero_div_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_int == '0) |=> !os_tick);

    assert_bit_with_os_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);

    assert_bit_cadence_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && ticks_since_bit == 5'd15) |-> bit_tick);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= sh_int);

endmodule

bind baud_frac_gen baud_frac_gen_chk #(.INT_W(INT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .os_tick  (os_tick),
    .bit_tick (bit_tick),
    .sh_int   (sh_int),
    .cnt      (div_cnt)
);

// File: tb/sim_baud_frac_gen.sv
module sim_baud_frac_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  prescale_sel = '0;
    logic [15:0] div_int = '0;
    logic [5:0]  div_frac = '0;
    logic [1:0]  ovs_sel = '0;
    logic        os_tick;
    logic        bit_tick;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    baud_frac_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .prescale_sel (prescale_sel),
        .div_int      (div_int),
        .div_frac     (div_frac),
        .ovs_sel      (ovs_sel),
        .os_tick      (os_tick),
        .bit_tick     (bit_tick)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int carry_of(input int p, input int f);
        return ((p * f) >> 6) - (((p - 1) * f) >> 6);
    endfunction

    function automatic int ticks_per_bit(input int m);
        return (m == 1) ? 8 : (m == 2) ? 3 : 16;
    endfunction

    // Configure while idle, enable, then check nt ticks against R3/R6 (and R4 if long).
    task automatic run_cfg(input int di, input int df, input int ps, input int om,
                           input int nt, input string tag);
        int cyc, last, tk, sum, gap, expg, n, ratio, limit;
        enable = 1'b0;
        div_int = 16'(di);
        div_frac = 6'(df);
        prescale_sel = 3'(ps);
        ovs_sel = 2'(om);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        cyc = 0; last = 0; tk = 0; sum = 0;
        n = ticks_per_bit(om);
        ratio = ps + 1;
        limit = (nt + 2) * ratio * (di + 1) + 20;
        while (tk < nt && cyc < limit) begin
            @(negedge clk);
            cyc++;
            if (bit_tick && !os_tick) check(1'b0, "R7 bit without tick", 1, 0);
            if (os_tick) begin
                tk++;
                if (tk >= 2) begin
                    gap = cyc - last;
                    expg = ratio * (di + carry_of(tk, df));
                    check(gap == expg, tag, gap, expg);
                    if (tk <= 65) sum += gap;
                end
                last = cyc;
                check(bit_tick == ((tk % n) == 0), "R6 bit strobe phase", int'(bit_tick),
                      int'((tk % n) == 0));
            end
        end
        check(tk == nt, "R3 tick count before timeout", tk, nt);
        if (nt >= 65) check(sum == ratio * (64 * di + df), "R4 64-period total", sum,
                            ratio * (64 * di + df));
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int cyc, t1, t2, t3, cnt;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(os_tick == 1'b0 && bit_tick == 1'b0, "R1 reset outputs", int'(os_tick), 0);
        rst_n = 1'b1;
        // R1: idle with a valid configuration
        div_int = 16'd1; div_frac = '0; prescale_sel = '0;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick) cnt++;
        end
        check(cnt == 0, "R1 no ticks while disabled", cnt, 0);

        // R10: every-cycle ticks
        run_cfg(1, 0, 0, 0, 40, "R10 minimum divisor gap");
        // R3: every fraction value
        for (int f = 0; f < 64; f++) run_cfg(2, f, 0, 0, 66, "R3 fractional gap");
        run_cfg(1, 63, 0, 0, 66, "R3 fraction 63 on divisor 1");
        // R4: worked example
        run_cfg(130, 13, 0, 0, 66, "R4 example gap");
        // R2 and R6: every ratio and every mode code
        for (int p = 0; p < 8; p++) run_cfg(3, 37, p, p % 4, 66, "R2 prescaled gap");
        for (int m = 0; m < 4; m++) run_cfg(2, 21, 1, m, 50, "R6 mode gap");

        // R9: interrupt mid-bit, then restart from period 1
        run_cfg(2, 45, 0, 0, 7, "R9 first run gap");
        run_cfg(2, 45, 0, 0, 40, "R9 restarted sequence gap");

        // R8: live change of the whole divisor applies at the next boundary
        enable = 1'b0; div_int = 16'd10; div_frac = '0; prescale_sel = '0; ovs_sel = '0;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        cyc = 0; t1 = -1; t2 = -1; t3 = -1;
        while (t1 < 0 && cyc < 100) begin @(negedge clk); cyc++; if (os_tick) t1 = cyc; end
        repeat (4) @(negedge clk);
        cyc += 4;
        div_int = 16'd3;
        while (t2 < 0 && cyc < 200) begin @(negedge clk); cyc++; if (os_tick) t2 = cyc; end
        while (t3 < 0 && cyc < 300) begin @(negedge clk); cyc++; if (os_tick) t3 = cyc; end
        check(t2 - t1 == 10, "R8 period in progress keeps old length", t2 - t1, 10);
        check(t3 - t2 == 3, "R8 new length after boundary", t3 - t2, 3);

        // R5: zero whole divisor halts, fraction ignored
        enable = 1'b0; div_int = '0; div_frac = 6'd40;
        repeat (3) @(negedge clk);
        enable = 1'b1;
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (os_tick) cnt++;
        end
        check(cnt == 0, "R5 no ticks with zero divisor", cnt, 0);
        div_int = 16'd4; div_frac = '0;
        cyc = 0; t1 = -1; t2 = -1;
        while (t1 < 0 && cyc < 100) begin @(negedge clk); cyc++; if (os_tick) t1 = cyc; end
        while (t2 < 0 && cyc < 200) begin @(negedge clk); cyc++; if (os_tick) t2 = cyc; end
        check(t1 > 0, "R5 ticking resumes", t1, 1);
        check(t2 - t1 == 4, "R5 resumed gap", t2 - t1, 4);

        // R1: disabling stops ticks
        enable = 1'b0;
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (os_tick || bit_tick) cnt++;
        end
        check(cnt == 0, "R1 quiet after disable", cnt, 0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule